// File: doc/BRIEF.md
# MII Receive and Carrier Status Generator

This block sits between a shared repeater backplane segment and an attached MAC. It drives the receive side of the MII and the carrier and collision status lines. Every output comes from a register on the MII clock. Its inputs are the segment's nibble stream: the nibble, a valid strobe, start-of-frame-delimiter and end-of-frame-delimiter markers, and an error-code flag. It also takes a segment-activity line, a segment collision line, the MAC's own transmit enable and a 10/100 speed select.

A frame is classified once, on its first nibble. If the MAC's transmit enable is high at that moment, the frame is the MAC's own echo and never raises receive-valid, even if transmit enable drops partway through the frame. In 100 Mbit/s mode:
- the start-of-frame-delimiter marker alone is enough to open the frame;
- the end-of-frame-delimiter nibble, and any nibble after it in the same frame, is stripped;
- the error flag is forwarded.

In 10 Mbit/s mode the delimiter markers are ignored and the error output stays low. The speed select is sampled only while the block is idle, so one frame never mixes the two modes.

Top module: `mii_rx_status`

## Requirements
- R1: Every output changes only on a rising clock edge. It reflects the inputs sampled at that edge, one cycle of latency.
- R2: rx_dv rises with the first nibble that has seg_vld high and stays high without a gap while seg_vld stays high. This holds unless R4 or R5 applies.
- R3: In 100 Mbit/s mode, seg_sfd high opens a frame even when seg_vld is low. rx_dv is then high in the cycle after that nibble.
- R4: In 100 Mbit/s mode, a nibble with seg_efd high, and every later nibble of the same frame, gives rx_dv low. A frame ends when both seg_vld and seg_sfd are low.
- R5: A frame whose first nibble arrives while mac_txen is high gives rx_dv low for its whole length, even after mac_txen falls.
- R6: rxd carries the registered segment nibble while rx_dv is high and is 4'h0 whenever rx_dv is low.
- R7: In 100 Mbit/s mode, rx_er is high exactly in the cycles after a nibble that has seg_err high inside a frame that is not the MAC's own.
- R8: In 10 Mbit/s mode, rx_er stays low and seg_sfd and seg_efd have no effect on rx_dv or rxd.
- R9: crs is high in the cycle after any of seg_act, seg_col or mac_txen is high, and low otherwise. This keeps carrier up through a collision and loops back the MAC's transmission.
- R10: col is high in the cycle after seg_col is high, in both modes.
- R11: mode_100 (1 = 100 Mbit/s, 0 = 10 Mbit/s) is taken in only at an edge where rx_dv is low and seg_vld and seg_sfd are both low. A change while a frame is open takes effect only after the frame ends.
- R12: An edge with rst high drives rx_dv, rx_er, crs and col low and rxd to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_100 | input | 1 | Speed select, 1 = 100 Mbit/s |
| seg_nib | input | 4 | Nibble from the segment |
| seg_vld | input | 1 | Segment nibble valid |
| seg_sfd | input | 1 | Nibble is a start-of-frame delimiter |
| seg_efd | input | 1 | Nibble is an end-of-frame delimiter |
| seg_err | input | 1 | Segment sensed an error code |
| seg_act | input | 1 | Segment is non-idle |
| seg_col | input | 1 | Collision on the segment |
| mac_txen | input | 1 | MAC transmit enable |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Receive nibble |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
A 100 Mbit/s vector sequence drives several frame shapes:
- A frame with a preamble, an SFD, data, an error nibble, an EFD and a trailing nibble. This separates plain validity from delimiter stripping and from error forwarding.
- A frame opened by the SFD marker alone. This shows that the marker, not only the valid strobe, starts a frame.
- Two frames that begin under mac_txen, one carrying an error. These show that the echo decision is latched for the whole frame and that it also masks rx_er.

Collision-only, collision-with-activity and transmit-only idle patterns isolate each source of crs. Directed runs in 10 Mbit/s mode confirm that the delimiter and error inputs have no effect there. A speed change issued mid-frame confirms the mode is held until two idle edges have passed. Reset is applied in the middle of a busy frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

   typedef enum logic {
      SPD_10  = 1'b0,
      SPD_100 = 1'b1
   } speed_e;

   localparam int unsigned NIB_W_DEF = 4;

endpackage

// File: rtl/mii_speed_hold.sv
module mii_speed_hold
   import mii_rx_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   mode_100,
   input  logic   rx_dv,
   input  logic   seg_busy,
   output speed_e spd
);

   speed_e spd_q;
   logic   idle_w;

   assign idle_w = !rx_dv && !seg_busy;

   always_ff @(posedge clk) begin
      if (rst)
         spd_q <= speed_e'(mode_100);
      else if (idle_w)
         spd_q <= speed_e'(mode_100);
   end

   assign spd = spd_q;

   // R11
   spd_held_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_dv || seg_busy) |=> $stable(spd_q));

endmodule

// File: rtl/mii_frame_track.sv
module mii_frame_track
   import mii_rx_pkg::*;
#(
   parameter int unsigned NIB_W     = NIB_W_DEF,
   parameter bit          STRIP_EFD = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  speed_e           spd,
   input  logic [NIB_W-1:0] seg_nib,
   input  logic             seg_vld,
   input  logic             seg_sfd,
   input  logic             seg_efd,
   input  logic             seg_err,
   input  logic             mac_txen,
   output logic             frm_on,
   output logic             dv_d,
   output logic [NIB_W-1:0] rxd_d,
   output logic             er_d
);

   localparam logic [NIB_W-1:0] NIB_ZERO = '0;

   logic is_100;
   logic in_frm_q;
   logic own_q;
   logic own_eff;
   logic done_q;
   logic done_n;
   logic cut_w;

   if (NIB_W < 1) begin : g_bad_width
      $error("mii_frame_track: NIB_W must be at least 1");
   end

   assign is_100  = (spd == SPD_100);
   assign frm_on  = seg_vld || (is_100 && seg_sfd);
   assign own_eff = in_frm_q ? own_q : mac_txen;

   if (STRIP_EFD) begin : g_strip
      assign done_n = frm_on && (done_q || (is_100 && seg_efd));
      assign cut_w  = is_100 && (seg_efd || done_q);
   end else begin : g_keep
      assign done_n = 1'b0;
      assign cut_w  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         in_frm_q <= 1'b0;
         own_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         in_frm_q <= frm_on;
         own_q    <= frm_on && own_eff;
         done_q   <= done_n;
      end
   end

   always_comb begin
      dv_d  = frm_on && !own_eff && !cut_w;
      rxd_d = dv_d ? seg_nib : NIB_ZERO;
      er_d  = is_100 && seg_err && frm_on && !own_eff;
   end

   // R5
   own_frame_chk: assert property (@(posedge clk) disable iff (rst)
      (in_frm_q && own_q && frm_on) |-> !dv_d);

   // R3
   sfd_open_chk: assert property (@(posedge clk) disable iff (rst)
      (is_100 && seg_sfd && !own_eff && !done_q && !seg_efd) |-> dv_d);

endmodule

// File: rtl/mii_status_out.sv
module mii_status_out
   import mii_rx_pkg::*;
#(
   parameter int unsigned NIB_W = NIB_W_DEF
)(
   input  logic             clk,
   input  logic             rst,
   input  speed_e           spd,
   input  logic             dv_d,
   input  logic [NIB_W-1:0] rxd_d,
   input  logic             er_d,
   input  logic             seg_act,
   input  logic             seg_col,
   input  logic             mac_txen,
   output logic             rx_dv,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_er,
   output logic             crs,
   output logic             col
);

   logic crs_d;

   assign crs_d = seg_act || seg_col || mac_txen;

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_dv <= 1'b0;
         rxd   <= '0;
         rx_er <= 1'b0;
         crs   <= 1'b0;
         col   <= 1'b0;
      end else begin
         rx_dv <= dv_d;
         rxd   <= rxd_d;
         rx_er <= er_d;
         crs   <= crs_d;
         col   <= seg_col;
      end
   end

   // R8
   er_low_10_chk: assert property (@(posedge clk) disable iff (rst)
      (spd == SPD_10) |=> !rx_er);

   // R12
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!rx_dv && !rx_er && !crs && !col && (rxd == '0)));

endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
   import mii_rx_pkg::*;
#(
   parameter int unsigned NIB_W     = NIB_W_DEF,
   parameter bit          STRIP_EFD = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             mode_100,
   input  logic [NIB_W-1:0] seg_nib,
   input  logic             seg_vld,
   input  logic             seg_sfd,
   input  logic             seg_efd,
   input  logic             seg_err,
   input  logic             seg_act,
   input  logic             seg_col,
   input  logic             mac_txen,
   output logic             rx_dv,
   output logic [NIB_W-1:0] rxd,
   output logic             rx_er,
   output logic             crs,
   output logic             col
);

   speed_e           spd;
   logic             frm_on;
   logic             dv_d;
   logic [NIB_W-1:0] rxd_d;
   logic             er_d;

   mii_speed_hold u_speed (
      .clk      (clk),
      .rst      (rst),
      .mode_100 (mode_100),
      .rx_dv    (rx_dv),
      .seg_busy (seg_vld || seg_sfd),
      .spd      (spd)
   );

   mii_frame_track #(
      .NIB_W     (NIB_W),
      .STRIP_EFD (STRIP_EFD)
   ) u_track (
      .clk      (clk),
      .rst      (rst),
      .spd      (spd),
      .seg_nib  (seg_nib),
      .seg_vld  (seg_vld),
      .seg_sfd  (seg_sfd),
      .seg_efd  (seg_efd),
      .seg_err  (seg_err),
      .mac_txen (mac_txen),
      .frm_on   (frm_on),
      .dv_d     (dv_d),
      .rxd_d    (rxd_d),
      .er_d     (er_d)
   );

   mii_status_out #(
      .NIB_W (NIB_W)
   ) u_out (
      .clk      (clk),
      .rst      (rst),
      .spd      (spd),
      .dv_d     (dv_d),
      .rxd_d    (rxd_d),
      .er_d     (er_d),
      .seg_act  (seg_act),
      .seg_col  (seg_col),
      .mac_txen (mac_txen),
      .rx_dv    (rx_dv),
      .rxd      (rxd),
      .rx_er    (rx_er),
      .crs      (crs),
      .col      (col)
   );

   // R9
   crs_src_chk: assert property (@(posedge clk) disable iff (rst)
      (seg_act || seg_col || mac_txen) |=> crs);

   // R10
   col_follow_chk: assert property (@(posedge clk) disable iff (rst)
      seg_col |=> col);

   // R2
   dv_nogap_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_dv && seg_vld && !seg_efd) |=> rx_dv);

   // R6
   rxd_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !frm_on |=> (rxd == '0));

endmodule

// File: tb/test_mii_rx_status.sv
`timescale 1ns/1ps
module test_mii_rx_status;

   logic       clk = 1'b0;
   logic       rst;
   logic       mode_100;
   logic [3:0] seg_nib;
   logic       seg_vld, seg_sfd, seg_efd, seg_err, seg_act, seg_col, mac_txen;
   logic       rx_dv, rx_er, crs, col;
   logic [3:0] rxd;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   mii_rx_status i_mii_rx_status (
      .clk(clk), .rst(rst), .mode_100(mode_100), .seg_nib(seg_nib),
      .seg_vld(seg_vld), .seg_sfd(seg_sfd), .seg_efd(seg_efd),
      .seg_err(seg_err), .seg_act(seg_act), .seg_col(seg_col),
      .mac_txen(mac_txen), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
      .crs(crs), .col(col)
   );

   // row: [18:12] vld sfd efd err act col txen, [11:8] nibble,
   //      [7:0] expected {dv, rxd, er, crs, col}
   localparam int NV = 19;
   localparam logic [18:0] VEC [0:NV-1] = '{
      19'b0000000_0000_0_0000_0_0_0,  // idle                R1
      19'b1000100_0101_1_0101_0_1_0,  // preamble            R2 R6
      19'b1100100_1101_1_1101_0_1_0,  // sfd                 R2
      19'b1000100_1010_1_1010_0_1_0,  // data                R6
      19'b1001100_0011_1_0011_1_1_0,  // error nibble        R7
      19'b1010100_0111_0_0000_0_1_0,  // efd stripped        R4
      19'b1000100_1001_0_0000_0_1_0,  // after efd           R4
      19'b0000000_0000_0_0000_0_0_0,  // frame end           R9
      19'b0000010_0000_0_0000_0_1_1,  // collision only      R9 R10
      19'b0000110_0000_0_0000_0_1_1,  // collision + act     R10
      19'b0000001_0000_0_0000_0_1_0,  // txen loopback       R9
      19'b1000101_0110_0_0000_0_1_0,  // own frame start     R5
      19'b1000100_0110_0_0000_0_1_0,  // own, txen dropped   R5
      19'b0000000_0000_0_0000_0_0_0,  // idle
      19'b0100100_1011_1_1011_0_1_0,  // sfd alone opens     R3
      19'b1000100_1100_1_1100_0_1_0,  // continues           R2
      19'b0001000_0000_0_0000_0_0_0,  // err outside frame   R7
      19'b1001001_0001_0_0000_0_1_0,  // own frame w/ err    R5 R7
      19'b0000000_0000_0_0000_0_0_0
   };

   task automatic drive(input logic [10:0] v);
      {seg_vld, seg_sfd, seg_efd, seg_err, seg_act, seg_col, mac_txen} = v[10:4];
      seg_nib = v[3:0];
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      logic [7:0] got;
      got = {rx_dv, rxd, rx_er, crs, col};
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      mode_100 = 1'b1;
      drive(11'b1111111_1111);
      @(negedge clk);
      step();
      chk("R12 reset state", 8'b0);
      rst = 1'b0;
      drive(11'b0);
      step();
      step();

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][18:8]);
         step();
         chk($sformatf("R1 vector %0d", i), VEC[i][7:0]);
      end

      // 10 Mbit/s mode: takes effect after idle edges (R11)
      mode_100 = 1'b0;
      drive(11'b0);
      step();
      step();
      drive(11'b1001100_0100);
      step();
      chk("R8 err ignored at 10", 8'b1_0100_0_1_0);
      drive(11'b1010100_1000);
      step();
      chk("R8 efd ignored at 10", 8'b1_1000_0_1_0);
      drive(11'b0100000_0010);
      step();
      chk("R8 sfd ignored at 10", 8'b0_0000_0_0_0);

      // mode change mid-frame is held
      drive(11'b1000100_0001);
      step();
      chk("R2 frame at 10", 8'b1_0001_0_1_0);
      mode_100 = 1'b1;
      drive(11'b1001100_0010);
      step();
      chk("R11 mode held in frame", 8'b1_0010_0_1_0);
      drive(11'b1001100_0011);
      step();
      chk("R11 mode still held", 8'b1_0011_0_1_0);
      drive(11'b0);
      step();
      chk("R11 frame end", 8'b0);
      step();
      drive(11'b1001100_0111);
      step();
      chk("R11 mode applied after idle", 8'b1_0111_1_1_0);

      // reset mid-frame
      drive(11'b1001111_1111);
      rst = 1'b1;
      step();
      chk("R12 reset during frame", 8'b0);
      rst = 1'b0;
      drive(11'b0);
      step();
      chk("R12 idle after reset", 8'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule